// File: doc/BRIEF.md
# Quadrature Integrate-and-Dump Downconverter

This block turns a one-bit sample stream into in-phase and quadrature sums for a single frequency bin centred on a 60 kHz carrier. The bit comes from a differential comparator pin that serves as a one-bit converter, with no amplifier in front of it. It is sampled at four times the carrier, which is 240 kHz and nominally locked to the carrier. Because the sampling is synchronous, mixing with the two reference carriers reduces to choosing, per sample phase, whether the sample is added, subtracted or skipped.

A programmable divider derives the sample strobe from the system clock. Each product stream is integrated over a window of 1/30 second, which is 8000 samples. At the end of the window the two sums are registered to the outputs with a one-cycle valid pulse, and integration of the next window starts at once. Windows do not overlap and no sample is lost between them, so the block acts as one DFT bin decimated to 30 Hz. Demodulation of phase or amplitude, carrier tracking and the analog front end sit downstream or upstream of this block.

Top module: `iqdc_top`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears the sample phase, the window position, both running sums and both output sums to zero, and holds sumValid low. The first strobe after reset is phase 0 and the first sample of a new window.
- R2: With divRatio = D held constant, a sample strobe occurs every D+1 clock cycles. The first strobe falls on the (D+1)-th rising edge after reset is released.
- R3: A sampled bit of 1 counts as +1 and a bit of 0 counts as -1. At sample phases 0, 1, 2 and 3, the in-phase weight is +1, 0, -1, 0 and the quadrature weight is 0, +1, 0, -1. The phase starts at 0 after reset and advances by one on every strobe, modulo 4. It keeps running across window boundaries.
- R4: A window holds exactly WINDOW_LEN consecutive samples. Each output sum is the weighted total of exactly those samples. The next window begins with the very next sample, so no sample is dropped or counted twice.
- R5: sumValid is high for exactly one clock cycle, in the cycle after the strobe of a window's last sample. iSum and qSum change only at that point and hold their values until the next window completes.
- R6: The sums are signed two's complement values, SUM_W bits wide. Their magnitude never exceeds ceil(WINDOW_LEN/2), so they never wrap. With the defaults (8000 samples, 14 bits) the range is ±4000.
- R7: rxBit passes through a two-stage synchronizer. The value used at a strobe is the rxBit value present at the rising edge two edges before the strobe edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| divRatio | input | DIV_W | Strobe divider setting; the strobe period is divRatio+1 clocks |
| rxBit | input | 1 | Comparator output, asynchronous to clk |
| iSum | output | SUM_W | In-phase sum of the last completed window, signed |
| qSum | output | SUM_W | Quadrature sum of the last completed window, signed |
| sumValid | output | 1 | One-cycle pulse marking a new iSum/qSum pair |

## Verification
The assertions assume only that reset is applied before checking begins. They hold for any rxBit waveform and any divRatio value, including changes to divRatio in the middle of a window. The bench is stricter: it changes divRatio only while reset is held, so the strobe grid it predicts stays aligned. It also drives each new input bit half a cycle before the first clock of its strobe period, so the bit has settled at least two edges before the strobe that uses it. Divider settings of 2, 4 and 7 are used, and the period of 3 places the input exactly at the synchronizer latency limit.

// File: rtl/iqdc_pkg.sv
package iqdc_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic       sampleEn;    // one clock per sample
    logic       lastSample;  // sampleEn on the final sample of a window
    logic [1:0] phase;       // reference phase of this sample
  } iqdcStrobe_t;
endpackage

// File: rtl/iqdc_ctrl.sv
module iqdc_ctrl
  import iqdc_pkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int WINDOW_LEN = 8000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] divRatio,
  output iqdcStrobe_t      strobes
);
  localparam int CNT_W = (WINDOW_LEN > 2) ? $clog2(WINDOW_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WINDOW_LEN - 1);

  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] sampleCnt;
  logic [1:0]       phase;
  logic             tick;
  logic             atLast;

  always_comb begin
    tick   = (divCnt >= divRatio);
    atLast = (sampleCnt == LAST_IDX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt    <= '0;
      sampleCnt <= '0;
      phase     <= '0;
    end else begin
      if (tick) begin
        divCnt <= '0;
        phase  <= phase + 2'd1;
        if (atLast) sampleCnt <= '0;
        else        sampleCnt <= sampleCnt + CNT_W'(1);
      end else begin
        divCnt <= divCnt + DIV_W'(1);
      end
    end
  end

  always_comb begin
    strobes.sampleEn   = tick;
    strobes.lastSample = tick && atLast;
    strobes.phase      = phase;
  end

  // R3
  phase_step_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.sampleEn |=> (strobes.phase == $past(strobes.phase) + 2'd1));

  // R3
  phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobes.sampleEn |=> $stable(strobes.phase));

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    sampleCnt <= LAST_IDX);

  // R4
  window_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.lastSample |=> (sampleCnt == '0));

  // R2
  div_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobes.sampleEn |=> $stable(sampleCnt));
endmodule

// File: rtl/iqdc_lane.sv
module iqdc_lane
  import iqdc_pkg::*;
#(
  parameter int SUM_W      = 14,
  parameter int WINDOW_LEN = 8000,
  parameter int PHASE_OFS  = 0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  iqdcStrobe_t             strobes,
  input  logic                    sampleBit,
  output logic signed [SUM_W-1:0] sumOut,
  output logic signed [SUM_W-1:0] accNow
);
  localparam logic [1:0] PH_POS = 2'(PHASE_OFS);
  localparam logic [1:0] PH_NEG = 2'(PHASE_OFS + 2);
  localparam logic signed [SUM_W-1:0] ONE       = SUM_W'(1);
  localparam logic signed [SUM_W-1:0] MINUS_ONE = -SUM_W'(1);
  localparam logic signed [SUM_W-1:0] BOUND     = SUM_W'((WINDOW_LEN + 1) / 2);

  logic signed [SUM_W-1:0] acc;
  logic signed [SUM_W-1:0] contrib;
  logic signed [SUM_W-1:0] nextAcc;

  always_comb begin
    contrib = '0;
    if (strobes.phase == PH_POS)      contrib = sampleBit ? ONE : MINUS_ONE;
    else if (strobes.phase == PH_NEG) contrib = sampleBit ? MINUS_ONE : ONE;
    nextAcc = acc + contrib;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      sumOut <= '0;
    end else if (strobes.sampleEn) begin
      if (strobes.lastSample) begin
        sumOut <= nextAcc;
        acc    <= '0;
      end else begin
        acc <= nextAcc;
      end
    end
  end

  assign accNow = acc;

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (acc <= BOUND) && (acc >= -BOUND));

  // R5
  sum_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobes.lastSample |=> $stable(sumOut));

  // R4
  acc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.lastSample |=> (acc == '0));
endmodule

// File: rtl/iqdc_datapath.sv
module iqdc_datapath
  import iqdc_pkg::*;
#(
  parameter int SUM_W      = 14,
  parameter int WINDOW_LEN = 8000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  iqdcStrobe_t             strobes,
  input  logic                    rxBit,
  output logic signed [SUM_W-1:0] iSum,
  output logic signed [SUM_W-1:0] qSum,
  output logic                    sumValid
);
  localparam int LANES = 2;

  logic syncA;
  logic syncB;
  logic signed [SUM_W-1:0] laneSum [LANES];
  logic signed [SUM_W-1:0] laneAcc [LANES];

  always_ff @(posedge clk) begin
    if (rst) begin
      syncA    <= 1'b0;
      syncB    <= 1'b0;
      sumValid <= 1'b0;
    end else begin
      syncA    <= rxBit;
      syncB    <= syncA;
      sumValid <= strobes.lastSample;
    end
  end

  // lane 0 is in-phase, lane 1 is quadrature (reference shifted one phase)
  for (genvar g = 0; g < LANES; g++) begin : gLane
    iqdc_lane #(
      .SUM_W     (SUM_W),
      .WINDOW_LEN(WINDOW_LEN),
      .PHASE_OFS (g)
    ) uLane (
      .clk      (clk),
      .rst      (rst),
      .strobes  (strobes),
      .sampleBit(syncB),
      .sumOut   (laneSum[g]),
      .accNow   (laneAcc[g])
    );
  end

  assign iSum = laneSum[0];
  assign qSum = laneSum[1];

  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    sumValid |=> !sumValid);

  // R4
  valid_fresh_chk: assert property (@(posedge clk) disable iff (rst)
    sumValid |-> (laneAcc[0] == '0) && (laneAcc[1] == '0));
endmodule

// File: rtl/iqdc_top.sv
module iqdc_top
  import iqdc_pkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int WINDOW_LEN = 8000,
  parameter int SUM_W      = 14
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [DIV_W-1:0]        divRatio,
  input  logic                    rxBit,
  output logic signed [SUM_W-1:0] iSum,
  output logic signed [SUM_W-1:0] qSum,
  output logic                    sumValid
);
  iqdcStrobe_t strobes;

  iqdc_ctrl #(
    .DIV_W     (DIV_W),
    .WINDOW_LEN(WINDOW_LEN)
  ) uCtrl (
    .clk     (clk),
    .rst     (rst),
    .divRatio(divRatio),
    .strobes (strobes)
  );

  iqdc_datapath #(
    .SUM_W     (SUM_W),
    .WINDOW_LEN(WINDOW_LEN)
  ) uData (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .rxBit   (rxBit),
    .iSum    (iSum),
    .qSum    (qSum),
    .sumValid(sumValid)
  );
endmodule

// File: tb/iqdc_top_test.sv
`timescale 1ns/1ps
module iqdc_top_test;
  localparam int DW = 16;
  localparam int WL = 22;
  localparam int SW = 14;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [DW-1:0]        divRatio = '0;
  logic                 rxBit = 1'b0;
  logic signed [SW-1:0] iSum;
  logic signed [SW-1:0] qSum;
  logic                 sumValid;

  int checks = 0;
  int fails  = 0;
  int sampIdx, inWin, eI, eQ, heldI, heldQ, curP;

  always #2.5 clk = ~clk;

  iqdc_top #(.DIV_W(DW), .WINDOW_LEN(WL), .SUM_W(SW)) uut (
    .clk(clk), .rst(rst), .divRatio(divRatio), .rxBit(rxBit),
    .iSum(iSum), .qSum(qSum), .sumValid(sumValid)
  );

  function automatic int refI(int ph);
    case (ph) 0: return 1; 2: return -1; default: return 0; endcase
  endfunction
  function automatic int refQ(int ph);
    case (ph) 1: return 1; 3: return -1; default: return 0; endcase
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // R1: reset and re-arm model; leaves the bench at a negedge with rst low
  task automatic doReset(int dr);
    @(negedge clk);
    rst = 1'b1;
    divRatio = DW'(dr);
    rxBit = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "sumValid in reset", int'(sumValid), 0);
    check("R1", "iSum in reset", int'(iSum), 0);
    check("R1", "qSum in reset", int'(qSum), 0);
    @(negedge clk);
    rst = 1'b0;
    curP = dr + 1;
    sampIdx = 0; inWin = 0; eI = 0; eQ = 0; heldI = 0; heldQ = 0;
  endtask

  // one strobe period; the bit is driven just before the first edge (R7)
  task automatic doSample(bit b);
    int ph, s;
    bit isLast;
    rxBit = b;
    ph = sampIdx % 4;
    s = b ? 1 : -1;
    eI += s * refI(ph);
    eQ += s * refQ(ph);
    sampIdx++;
    inWin++;
    isLast = (inWin == WL);
    for (int j = 0; j < curP; j++) begin
      @(posedge clk);
      #1;
      if (j == curP - 1 && isLast) begin
        check("R5", "sumValid at window end", int'(sumValid), 1);
        check("R4", "iSum of window", int'(iSum), eI);
        check("R4", "qSum of window", int'(qSum), eQ);
        heldI = eI; heldQ = eQ;
        eI = 0; eQ = 0; inWin = 0;
      end else begin
        check("R2", "sumValid off-strobe", int'(sumValid), 0);
        check("R5", "iSum held", int'(iSum), heldI);
        check("R5", "qSum held", int'(qSum), heldQ);
      end
    end
    @(negedge clk);
  endtask

  // mode 0 ones, 1 zeros, 2 matched to both references, 3 inverted, 4 random
  task automatic runSamples(int mode, int n);
    bit b;
    for (int k = 0; k < n; k++) begin
      case (mode)
        0: b = 1'b1;
        1: b = 1'b0;
        2: b = ((sampIdx % 4) < 2);
        3: b = ((sampIdx % 4) >= 2);
        default: b = 1'($urandom);
      endcase
      doSample(b);
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: run did not complete actual=1 expected=0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20130308));
    // R2 R3 R6: divider 4, matched pattern hits the full magnitude bound
    doReset(4);
    runSamples(2, WL);
    check("R6", "matched iSum at bound", heldI, (WL + 1) / 2);
    check("R3", "matched qSum", heldQ, WL / 2);
    // R3 phase continues into the second window (starts at phase 2)
    runSamples(3, WL);
    runSamples(0, WL);
    runSamples(1, WL);
    // R7: period of 3 puts the bit exactly two edges ahead of the strobe
    doReset(2);
    runSamples(0, WL);
    check("R7", "all-ones window i", heldI, 1);
    check("R7", "all-ones window q", heldQ, 1);
    runSamples(4, 3 * WL);
    // R1: reset in the middle of a window restarts phase and window
    runSamples(4, WL / 2);
    doReset(7);
    runSamples(2, WL);
    check("R1", "post-reset window starts at phase 0", heldI, (WL + 1) / 2);
    runSamples(4, 4 * WL);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule